// File: doc/BRIEF.md
# Serial Controller Host Register Interface

This block sits between a host bus and the serial engine of a UART-style controller. It decodes four byte addresses. Offset 0 is the data port: a write hands a byte to the transmitter and a read takes one from the receiver. Offset 1 is a read-only status byte. Offsets 2 and 3 are write-only configuration registers, named the command and setup registers here.

The command register decodes into several settings: parity use and mode, receive echo, transmit interrupt and break, receive interrupt enable, and the levels of the RTS and DTR modem pins. The setup register decodes into stop-bit selection, word length, receiver clock source and rate selection. The block also merges the receive-full and transmit-empty flags into a sticky interrupt bit. That bit is reported in the status byte and drives an active-low interrupt request pin.

The serializer, deserializer and rate generator are outside this block. They connect through one-cycle strobes (`txLoad`, `rxAck`) and level flags (`txEmpty`, `rxFull`, error flags).

Top module: `serHostRegs`

## Requirements
- R1: After reset the command and setup registers are 0 and the interrupt bit is 0. The outputs are then `rtsPin`=1, `dtrPin`=1, `irqN`=1, `txBreak`=0, `echoEn`=0, `parityEn`=0, `parityMode`=0, `stopSel`=0, `wordLen`=0, `rxClkInt`=0 and `rateSel`=0.
- R2: A selected write to offset 0 asserts `txLoad` in that same cycle, with `txData` equal to `wrData`. `txLoad` is 0 in every other cycle.
- R3: A selected read of offset 0 returns `rxData` on `rdData` and asserts `rxAck` in that same cycle.
- R4: A read of offset 1 returns the status byte. From bit 7 down to bit 0 it holds: interrupt bit, `dsrLevel`, `dcdLevel`, `txEmpty`, `rxFull`, `errOverrun`, `errFraming`, `errParity`. The modem bits read 1 when their input is high.
- R5: A read of offset 2 or offset 3 returns 8'h00.
- R6: Command bits 3:2 set the transmit behaviour from the next cycle on. 00 gives `rtsPin`=1 with no transmit interrupt. 01 gives `rtsPin`=0 with the transmit interrupt enabled. 10 gives `rtsPin`=0 with no transmit interrupt. 11 gives `rtsPin`=0 and `txBreak`=1 with no transmit interrupt.
- R7: Command bit 0 set to 1 drives `dtrPin` low, and set to 0 drives it high. Command bit 1 set to 0 enables the receive interrupt, and set to 1 disables it. Bit 4 drives `echoEn`, bit 5 drives `parityEn`, and bits 7:6 drive `parityMode`.
- R8: Setup register bit 7 drives `stopSel`, bits 6:5 drive `wordLen`, bit 4 drives `rxClkInt` (1 = internal) and bits 3:0 drive `rateSel`.
- R9: The interrupt bit becomes 1 on the clock edge at which the interrupt condition rises from 0 to 1. The condition is (`rxFull` and the receive interrupt enabled) or (`txEmpty` and the transmit interrupt enabled). `irqN` is the inverse of the interrupt bit.
- R10: A status read clears the interrupt bit at the end of the read cycle. If the condition rises in that same cycle, the set wins and the bit stays 1.
- R11: When `sel` is 0, no register changes and neither `txLoad` nor `rxAck` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Block select |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable |
| addr | input | 2 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| txData | output | 8 | Byte to transmitter |
| txLoad | output | 1 | Transmit byte strobe |
| txEmpty | input | 1 | Transmitter holding register empty |
| rxData | input | 8 | Byte from receiver |
| rxFull | input | 1 | Receiver holding register full |
| rxAck | output | 1 | Receive byte taken strobe |
| errOverrun | input | 1 | Receive overrun flag |
| errFraming | input | 1 | Receive framing error flag |
| errParity | input | 1 | Receive parity error flag |
| dsrLevel | input | 1 | DSR input level |
| dcdLevel | input | 1 | DCD input level |
| irqN | output | 1 | Interrupt request, active low |
| rtsPin | output | 1 | RTS pin level |
| dtrPin | output | 1 | DTR pin level |
| txBreak | output | 1 | Send break |
| echoEn | output | 1 | Receive echo enable |
| parityEn | output | 1 | Parity in use |
| parityMode | output | 2 | Parity mode select |
| stopSel | output | 1 | Stop-bit selection |
| wordLen | output | 2 | Word length code |
| rxClkInt | output | 1 | Receiver clock is internal |
| rateSel | output | 4 | Rate select code |

## Verification
A status read that clears the interrupt bit can fall in the same cycle as a fresh rise of the interrupt condition. The bench provokes this by raising `rxFull`, with the receive interrupt enabled, on the same edge at which a status read is issued. The judgement has two parts. The byte returned by that read must show bit 7 clear, and `irqN` must be low after the edge, because the set takes priority over the clear. A separate case checks that a plain read, with no new rise, leaves `irqN` high even though the condition is still asserted.

// File: rtl/serHostPkg.sv
package serHostPkg;
  localparam int OFS_DATA   = 0;
  localparam int OFS_STATUS = 1;
  localparam int OFS_CMD    = 2;
  localparam int OFS_SETUP  = 3;

  // strobes from access decode to the register datapath
  typedef struct packed {
    logic txLoad;
    logic rxAck;
    logic statusRd;
    logic cmdWr;
    logic setupWr;
  } hostStrobes_t;
endpackage

// File: rtl/serHostDecode.sv
module serHostDecode
  import serHostPkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              sel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output hostStrobes_t      stb
);
  logic wrAcc, rdAcc;

  always_comb begin
    wrAcc        = sel & wrEn;
    rdAcc        = sel & rdEn;
    stb.txLoad   = wrAcc & (addr == ADDR_W'(OFS_DATA));
    stb.cmdWr    = wrAcc & (addr == ADDR_W'(OFS_CMD));
    stb.setupWr  = wrAcc & (addr == ADDR_W'(OFS_SETUP));
    stb.rxAck    = rdAcc & (addr == ADDR_W'(OFS_DATA));
    stb.statusRd = rdAcc & (addr == ADDR_W'(OFS_STATUS));
  end
endmodule

// File: rtl/serHostRegFile.sv
module serHostRegFile
  import serHostPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hostStrobes_t      stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic              errOverrun,
  input  logic              errFraming,
  input  logic              errParity,
  input  logic              dsrLevel,
  input  logic              dcdLevel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN,
  output logic              rtsPin,
  output logic              dtrPin,
  output logic              txBreak,
  output logic              echoEn,
  output logic              parityEn,
  output logic [1:0]        parityMode,
  output logic              stopSel,
  output logic [1:0]        wordLen,
  output logic              rxClkInt,
  output logic [RATE_W-1:0] rateSel,
  output logic              rxIntEn,
  output logic              txIntEn
);
  localparam int STAT_W = 8;

  logic [DATA_W-1:0] cmdReg, setupReg;
  logic              irqBit, condPrev, irqCond, condRise;
  logic [STAT_W-1:0] statusByte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdReg   <= '0;
      setupReg <= '0;
      irqBit   <= 1'b0;
      condPrev <= 1'b0;
    end else begin
      if (stb.cmdWr)   cmdReg   <= wrData;
      if (stb.setupWr) setupReg <= wrData;
      condPrev <= irqCond;
      if (condRise)          irqBit <= 1'b1;
      else if (stb.statusRd) irqBit <= 1'b0;
    end
  end

  // command decode
  always_comb begin
    rtsPin     = (cmdReg[3:2] == 2'b00);
    txIntEn    = (cmdReg[3:2] == 2'b01);
    txBreak    = (cmdReg[3:2] == 2'b11);
    rxIntEn    = ~cmdReg[1];
    dtrPin     = ~cmdReg[0];
    echoEn     = cmdReg[4];
    parityEn   = cmdReg[5];
    parityMode = cmdReg[7:6];
  end

  // setup decode
  always_comb begin
    stopSel  = setupReg[7];
    wordLen  = setupReg[6:5];
    rxClkInt = setupReg[4];
    rateSel  = setupReg[RATE_W-1:0];
  end

  always_comb begin
    irqCond  = (rxFull & rxIntEn) | (txEmpty & txIntEn);
    condRise = irqCond & ~condPrev;
    irqN     = ~irqBit;
    statusByte = {irqBit, dsrLevel, dcdLevel, txEmpty, rxFull,
                  errOverrun, errFraming, errParity};
  end

  always_comb begin
    unique case (addr)
      ADDR_W'(OFS_DATA):   rdData = rxData;
      ADDR_W'(OFS_STATUS): rdData = DATA_W'(statusByte);
      default:             rdData = '0;
    endcase
  end
endmodule

// File: rtl/serHostRegs.sv
module serHostRegs
  import serHostPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] txData,
  output logic              txLoad,
  input  logic              txEmpty,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxFull,
  output logic              rxAck,
  input  logic              errOverrun,
  input  logic              errFraming,
  input  logic              errParity,
  input  logic              dsrLevel,
  input  logic              dcdLevel,
  output logic              irqN,
  output logic              rtsPin,
  output logic              dtrPin,
  output logic              txBreak,
  output logic              echoEn,
  output logic              parityEn,
  output logic [1:0]        parityMode,
  output logic              stopSel,
  output logic [1:0]        wordLen,
  output logic              rxClkInt,
  output logic [RATE_W-1:0] rateSel
);
  hostStrobes_t stb;
  logic         rxIntEn, txIntEn;

  serHostDecode #(.ADDR_W(ADDR_W)) decode_i (
    .sel(sel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  serHostRegFile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .addr(addr), .wrData(wrData),
    .rxData(rxData), .rxFull(rxFull), .txEmpty(txEmpty),
    .errOverrun(errOverrun), .errFraming(errFraming), .errParity(errParity),
    .dsrLevel(dsrLevel), .dcdLevel(dcdLevel), .rdData(rdData), .irqN(irqN),
    .rtsPin(rtsPin), .dtrPin(dtrPin), .txBreak(txBreak), .echoEn(echoEn),
    .parityEn(parityEn), .parityMode(parityMode), .stopSel(stopSel),
    .wordLen(wordLen), .rxClkInt(rxClkInt), .rateSel(rateSel),
    .rxIntEn(rxIntEn), .txIntEn(txIntEn)
  );

  assign txData = wrData;
  assign txLoad = stb.txLoad;
  assign rxAck  = stb.rxAck;
endmodule

// File: rtl/serHostRegsChk.sv
module serHostRegsChk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFull,
  input logic              txEmpty,
  input logic              txLoad,
  input logic              rxAck,
  input logic              irqN,
  input logic              rtsPin,
  input logic              dtrPin,
  input logic              txBreak,
  input logic              rxIntEn,
  input logic              txIntEn
);
  logic cond, statRd, cmdWr;
  assign cond   = (rxFull & rxIntEn) | (txEmpty & txIntEn);
  assign statRd = sel & rdEn & (addr == ADDR_W'(1));
  assign cmdWr  = sel & wrEn & (addr == ADDR_W'(2));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cond) |=> !irqN);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statRd && !$rose(cond)) |=> irqN);

  // R6
  rts_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWr && wrData[3:2] == 2'b00) |=> (rtsPin && !txBreak));

  // R7
  dtr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdWr |=> (dtrPin == !$past(wrData[0])));

  // R11
  no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!txLoad && !rxAck));

  // R3
  rx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxAck |-> (rdData == rxData));
endmodule

bind serHostRegs serHostRegsChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .rxData(rxData), .rxFull(rxFull),
  .txEmpty(txEmpty), .txLoad(txLoad), .rxAck(rxAck), .irqN(irqN),
  .rtsPin(rtsPin), .dtrPin(dtrPin), .txBreak(txBreak),
  .rxIntEn(rxIntEn), .txIntEn(txIntEn)
);

// File: tb/serHostRegs_tb_top.sv
module serHostRegs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 0, wrEn = 0, rdEn = 0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0, rdData, txData, rxData = '0;
  logic       txLoad, rxAck, txEmpty = 0, rxFull = 0;
  logic       errOverrun = 0, errFraming = 0, errParity = 0;
  logic       dsrLevel = 0, dcdLevel = 0;
  logic       irqN, rtsPin, dtrPin, txBreak, echoEn, parityEn, stopSel, rxClkInt;
  logic [1:0] parityMode, wordLen;
  logic [3:0] rateSel;
  int         checks = 0, errors = 0;
  logic       finished = 1'b0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  serHostRegs dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .txData(txData),
    .txLoad(txLoad), .txEmpty(txEmpty), .rxData(rxData), .rxFull(rxFull),
    .rxAck(rxAck), .errOverrun(errOverrun), .errFraming(errFraming),
    .errParity(errParity), .dsrLevel(dsrLevel), .dcdLevel(dcdLevel),
    .irqN(irqN), .rtsPin(rtsPin), .dtrPin(dtrPin), .txBreak(txBreak),
    .echoEn(echoEn), .parityEn(parityEn), .parityMode(parityMode),
    .stopSel(stopSel), .wordLen(wordLen), .rxClkInt(rxClkInt), .rateSel(rateSel)
  );

  // {command byte, expected {rts,dtr,brk,echo,parEn,parMode,0}}
  localparam logic [15:0] CMD_VEC [9] = '{
    16'h00C0, 16'h0180, 16'h0440, 16'h0840, 16'h0C60,
    16'h10D0, 16'h20C8, 16'hE0CE, 16'h4D22
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wrEn = 1; addr = a; wrData = d;
    @(negedge clk); sel = 0; wrEn = 0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rdEn = 1; addr = a;
    #1 d = rdData;
    @(negedge clk); sel = 0; rdEn = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pins", {rtsPin, dtrPin, irqN, txBreak}, 4'b1110);
    chk("R1 cmd fields", {echoEn, parityEn, parityMode}, 4'b0);
    chk("R1 setup fields", {stopSel, wordLen, rxClkInt, rateSel}, 8'h00);

    // R6 R7 command decode table
    for (int i = 0; i < 9; i++) begin
      busWr(2'd2, CMD_VEC[i][15:8]);
      chk("R6/R7 cmd table",
          {rtsPin, dtrPin, txBreak, echoEn, parityEn, parityMode, 1'b0},
          CMD_VEC[i][7:0]);
    end

    // R8 setup decode
    busWr(2'd3, 8'hB7);
    chk("R8 setup", {stopSel, wordLen, rxClkInt, rateSel}, {1'b1, 2'b01, 1'b1, 4'h7});
    busWr(2'd3, 8'h4A);
    chk("R8 setup", {stopSel, wordLen, rxClkInt, rateSel}, {1'b0, 2'b10, 1'b0, 4'hA});

    // R5 write-only registers read as zero
    busRd(2'd2, got); chk("R5 cmd read", got, 8'h00);
    busRd(2'd3, got); chk("R5 setup read", got, 8'h00);

    // R2 data write
    @(negedge clk); sel = 1; wrEn = 1; addr = 2'd0; wrData = 8'hA5;
    #1 chk("R2 txLoad", {txLoad, txData}, {1'b1, 8'hA5});
    @(negedge clk); sel = 0; wrEn = 0;
    #1 chk("R2 txLoad idle", txLoad, 1'b0);

    // R3 data read
    rxData = 8'h3C;
    @(negedge clk); sel = 1; rdEn = 1; addr = 2'd0;
    #1 chk("R3 read", {rxAck, rdData}, {1'b1, 8'h3C});
    @(negedge clk); sel = 0; rdEn = 0;
    #1 chk("R3 ack idle", rxAck, 1'b0);

    // R4 status layout, interrupts off
    busWr(2'd2, 8'h02);
    dsrLevel = 1; dcdLevel = 0; txEmpty = 1; rxFull = 0;
    errOverrun = 1; errFraming = 0; errParity = 1;
    busRd(2'd1, got); chk("R4 status a", got, 8'h55);
    dsrLevel = 0; dcdLevel = 1; txEmpty = 0; rxFull = 1;
    errOverrun = 0; errFraming = 1; errParity = 0;
    busRd(2'd1, got); chk("R4 status b", got, 8'h2A);
    chk("R9 disabled no irq", irqN, 1'b1);

    // R11 unselected write ignored (cmd stays 0x02: rts 1, dtr 1)
    @(negedge clk); sel = 0; wrEn = 1; rdEn = 1; addr = 2'd2; wrData = 8'hFF;
    #1 chk("R11 no strobes", {txLoad, rxAck}, 2'b00);
    @(negedge clk); wrEn = 0; rdEn = 0;
    chk("R11 cmd unchanged", {rtsPin, dtrPin, txBreak}, 3'b110);

    // R9 receive interrupt
    errFraming = 0; dcdLevel = 0; rxFull = 0; txEmpty = 0;
    busWr(2'd2, 8'h00);
    @(negedge clk); rxFull = 1;
    @(negedge clk); chk("R9 rx irq", irqN, 1'b0);
    busRd(2'd1, got); chk("R9 status irq bit", got, 8'h88);
    // R10 cleared, condition still high but not rising
    chk("R10 cleared", irqN, 1'b1);
    @(negedge clk); chk("R10 stays clear", irqN, 1'b1);

    // R9 transmit interrupt (tx int, rx disabled)
    rxFull = 0;
    busWr(2'd2, 8'h06);
    @(negedge clk); txEmpty = 1;
    @(negedge clk); chk("R9 tx irq", irqN, 1'b0);
    busRd(2'd1, got); chk("R10 tx clear", irqN, 1'b1);

    // R10 collision: rise and status read on the same edge
    txEmpty = 0;
    busWr(2'd2, 8'h00);
    @(negedge clk); sel = 1; rdEn = 1; addr = 2'd1; rxFull = 1;
    #1 got = rdData;
    @(negedge clk); sel = 0; rdEn = 0;
    chk("R10 collision read", got[7], 1'b0);
    chk("R10 set wins", irqN, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule